// File: doc/BRIEF.md
# Four-Phase Handshake Word Crossing

This block carries a 12-bit data word, such as a slowly refreshed sensor value, from a slow source clock domain into a faster destination clock domain. The two clocks have no fixed phase relation. The wide bus is never sampled while it is changing. On a load strobe, the source side latches the word into a holding register and raises a single request flag. The holding register stays frozen until the whole exchange is over.

Only two single-bit controls pass through synchronizers. The request goes through a two-flop chain into the destination. The acknowledge goes through a two-flop chain back into the source. After the destination sees the synchronized request, it copies the frozen word into its output register and signals the update with a one-cycle pulse. It then answers with the acknowledge. The source drops its request once it sees the acknowledge. The destination drops the acknowledge once it sees the request fall. The source reports busy for the whole round trip, and loads that arrive in that time are discarded.

Top module: `hs_word_xfer`

## Requirements
- R1: While a domain's active-low reset is held, its state clears at the next clock edge of that domain. The source shows `src_busy` = 0, and the destination shows `dst_data` = 0 and `dst_new` = 0.
- R2: A `src_load` that is sampled high while the source is idle is accepted. `src_busy` is 1 from the next source clock edge until the handshake completes.
- R3: A `src_load` that arrives while `src_busy` is 1 is ignored. The held word does not change, and the value delivered is the word that was accepted.
- R4: The destination updates its output only after its two-flop synchronized copy of the request is high. It then presents exactly the 12-bit word that the source accepted.
- R5: The source holds the request high until its synchronized acknowledge is high, and only then lowers it.
- R6: The destination lowers the acknowledge only after its synchronized request is low. `src_busy` returns to 0 only after the synchronized acknowledge has fallen, and only then can a new word be accepted.
- R7: Each completed transfer produces exactly one `dst_new` pulse, one destination cycle wide, in the cycle that `dst_data` takes the new word. `dst_data` holds its value in every other cycle.
- R8: Any 12-bit value is delivered unchanged, in the order the words were sent. This includes all-zeros, all-ones, jumps across every bit, and the same value sent twice in a row, which produces two pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source synchronous reset, active low |
| src_load | input | 1 | Strobe to accept `src_data` when idle |
| src_data | input | 12 | Word to be sent |
| src_busy | output | 1 | High while a transfer is in flight |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination synchronous reset, active low |
| dst_data | output | 12 | Last word received |
| dst_new | output | 1 | One-cycle pulse when `dst_data` takes a new word |

## Verification
The bench sends the full-range corner cases (zero, all-ones, a repeated word, and a jump across every bit), followed by random words. It checks that they arrive in order.

On some transfers it strobes a different word while busy is high. A design that did not discard these loads would deliver the injected word, or a torn mix of the two words.

It checks that each transfer gives one single-cycle pulse, and that the output register never moves without that pulse. A design that skipped the acknowledge return, or dropped its acknowledge early, would either deliver the same word twice or lose a word. The bench also confirms that busy has cleared before each new word is sent.

// File: rtl/hs_word_pkg.sv
`timescale 1ns/1ps
// Shared types for the handshake word crossing.
package hs_word_pkg;
    // Source-side handshake phases
    typedef enum logic [1:0] {
        SRC_IDLE     = 2'd0,  // ready for a new word
        SRC_WAIT_ACK = 2'd1,  // request high, waiting for acknowledge
        SRC_WAIT_REL = 2'd2   // request low, waiting for acknowledge to fall
    } src_phase_t;
endpackage

// File: rtl/hs_flag_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for one control flag.
// Assumes: d is a level that stays put for several destination cycles.
module hs_flag_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_src_side.sv
`timescale 1ns/1ps
// Source half of the four-phase crossing: accepts a word, freezes it and
// runs request until the synchronized acknowledge has come and gone.
// Assumes: ack_sync is already synchronized into this clock domain.
module hs_src_side
    import hs_word_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ack_sync,
    output logic              req,
    output logic [DATA_W-1:0] word,
    output logic              busy
);
    src_phase_t phase;

    // handshake phase, request flag and frozen word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= SRC_IDLE;
            req   <= 1'b0;
            word  <= '0;
        end else begin
            case (phase)
                SRC_IDLE: if (load) begin
                    word  <= data_in;
                    req   <= 1'b1;
                    phase <= SRC_WAIT_ACK;
                end
                SRC_WAIT_ACK: if (ack_sync) begin
                    req   <= 1'b0;
                    phase <= SRC_WAIT_REL;
                end
                SRC_WAIT_REL: if (!ack_sync) phase <= SRC_IDLE;
                default: phase <= SRC_IDLE;
            endcase
        end
    end

    // busy for the whole round trip
    assign busy = (phase != SRC_IDLE);

    // R3: the held word never moves while a transfer is in flight
    p_word_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(word));
    // R5: request falls only after the acknowledge was seen
    p_req_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> $past(ack_sync));
    // R2: a raised request always shows as busy
    p_req_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> busy);
endmodule

// File: rtl/hs_dst_side.sv
`timescale 1ns/1ps
// Destination half: on a synchronized request it captures the frozen word,
// pulses new-data once, and answers with an acknowledge level.
// Assumes: word_in is held stable by the source while req_sync is high.
module hs_dst_side #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_sync,
    input  logic [DATA_W-1:0] word_in,
    output logic              ack,
    output logic [DATA_W-1:0] data_out,
    output logic              new_pulse
);
    // capture, pulse and acknowledge handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack       <= 1'b0;
            data_out  <= '0;
            new_pulse <= 1'b0;
        end else begin
            new_pulse <= 1'b0;
            if (req_sync && !ack) begin
                data_out  <= word_in;
                new_pulse <= 1'b1;
                ack       <= 1'b1;
            end else if (!req_sync && ack) begin
                ack <= 1'b0;
            end
        end
    end

    // R7: pulse is one cycle wide
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        new_pulse |=> !new_pulse);
    // R7: output changes only together with the pulse
    p_out_with_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_out) |-> new_pulse);
    // R4: acknowledge rises only after a synchronized request
    p_capture_on_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(req_sync));
    // R6: acknowledge falls only after the request was seen low
    p_ack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> !$past(req_sync));
endmodule

// File: rtl/hs_word_xfer.sv
`timescale 1ns/1ps
// Top of the word crossing. Only req and ack go through synchronizers;
// the word crosses as a plain bus because it is frozen during the exchange.
// Assumes: src_clk and dst_clk are unrelated.
module hs_word_xfer #(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic              src_load,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_busy,
    input  logic              dst_clk,
    input  logic              dst_rst_n,
    output logic [DATA_W-1:0] dst_data,
    output logic              dst_new
);
    logic              req, req_sync, ack, ack_sync;
    logic [DATA_W-1:0] held_word;

    hs_src_side #(.DATA_W(DATA_W)) u_src (
        .clk(src_clk), .rst_n(src_rst_n), .load(src_load), .data_in(src_data),
        .ack_sync(ack_sync), .req(req), .word(held_word), .busy(src_busy));

    hs_flag_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(dst_clk), .rst_n(dst_rst_n), .d(req), .q(req_sync));

    hs_flag_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(src_clk), .rst_n(src_rst_n), .d(ack), .q(ack_sync));

    hs_dst_side #(.DATA_W(DATA_W)) u_dst (
        .clk(dst_clk), .rst_n(dst_rst_n), .req_sync(req_sync),
        .word_in(held_word), .ack(ack), .data_out(dst_data), .new_pulse(dst_new));
endmodule

// File: tb/hs_word_xfer_test.sv
`timescale 1ns/1ps
module hs_word_xfer_test;
    localparam int W = 12;

    logic         src_clk = 1'b0, dst_clk = 1'b0;
    logic         src_rst_n = 1'b0, dst_rst_n = 1'b0;
    logic         src_load = 1'b0;
    logic [W-1:0] src_data = '0;
    logic         src_busy, dst_new;
    logic [W-1:0] dst_data;

    int errors = 0, checks = 0;
    logic [W-1:0] exp_q [0:255];
    int wr_i = 0, rd_i = 0;
    logic [W-1:0] last_out = '0;
    bit finished = 1'b0;

    hs_word_xfer uut (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_load(src_load),
        .src_data(src_data), .src_busy(src_busy), .dst_clk(dst_clk),
        .dst_rst_n(dst_rst_n), .dst_data(dst_data), .dst_new(dst_new));

    // slow source clock, about 24.4 MHz
    always #20.5 src_clk = ~src_clk;
    // 50 MHz destination clock with an offset start, no fixed phase relation
    initial begin
        #7;
        forever #10 dst_clk = ~dst_clk;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // word the bench injects while busy; it never equals w
    function automatic logic [W-1:0] intruder(input logic [W-1:0] w);
        return ~w ^ 12'h5A5;
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // destination monitor: order, pulse width and output hold
    always @(negedge dst_clk) begin
        if (dst_rst_n) begin
            if (dst_new) begin
                if (rd_i < wr_i)
                    check(dst_data == exp_q[rd_i % 256], "R4 R3 R8 word", dst_data, exp_q[rd_i % 256]);
                else
                    check(1'b0, "R7 extra pulse", rd_i, wr_i);
                rd_i++;
                last_out = dst_data;
            end else if (dst_data != last_out) begin
                check(1'b0, "R7 output moved without pulse", dst_data, last_out);
            end
        end
    end

    task automatic send(input logic [W-1:0] w, input bit poke);
        int n = 0;
        @(negedge src_clk);
        while (src_busy) @(negedge src_clk);
        src_load = 1'b1;
        src_data = w;
        exp_q[wr_i % 256] = w;
        wr_i++;
        @(negedge src_clk);
        src_load = 1'b0;
        check(src_busy == 1'b1, "R2 busy after load", src_busy, 1);
        if (poke) begin // R3: strobe another word mid-transfer
            src_load = 1'b1;
            src_data = intruder(w);
            @(negedge src_clk);
            src_load = 1'b0;
        end
        while (src_busy && n < 2000) begin
            @(negedge src_clk);
            n++;
        end
        check(!src_busy, "R6 busy cleared", src_busy, 0);
        check(rd_i == wr_i, "R7 one pulse per transfer", rd_i, wr_i);
    endtask

    initial begin
        int seed_dummy;
        repeat (3) @(negedge dst_clk);
        // R1: reset state
        check(src_busy == 1'b0, "R1 busy", src_busy, 0);
        check(dst_data == '0, "R1 data", dst_data, 0);
        check(dst_new == 1'b0, "R1 new", dst_new, 0);
        @(negedge src_clk);
        src_rst_n = 1'b1;
        dst_rst_n = 1'b1;
        // directed corner words (R8)
        send(12'h000, 1'b0);
        send(12'hFFF, 1'b1);
        send(12'hFFF, 1'b0);
        send(12'h800, 1'b1);
        send(12'h7FF, 1'b0);
        send(12'hA5A, 1'b1);
        seed_dummy = $urandom(32'd20240611);
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] w;
            w = W'($urandom % 4096);
            send(w, 1'($urandom % 2));
        end
        repeat (20) @(negedge dst_clk);
        check(rd_i == wr_i, "R8 all words delivered", rd_i, wr_i);
        summary();
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge dst_clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", rd_i, wr_i);
        summary();
    end
endmodule